// File: doc/BRIEF.md
# Fault Status Latch with Coded Reset

This block drives the single status line that a host reads to learn whether an output-driver array is healthy. The line combines live conditions with three remembered ones. The live conditions are a short-circuit flag for each channel, a present overtemperature flag and a standby flag. The standby flag is high while every command bit is zero, so the host can check that the line can reach its high level. The remembered conditions are two framing errors and an overtemperature event.

Each remembered condition is released by a different falling clock edge of the next serial frame. The host can therefore tell which fault occurred by counting how many clocks of the following frame pass before the line drops. A separate serial interface block supplies one-cycle event pulses: a short-frame pulse, a long-frame pulse, and a falling-edge pulse that carries the 1-based index of that clock within the current frame. Temperature hysteresis is applied before the overtemperature flag reaches this block.

Top module: `fault_status_latch`

## Requirements
- R1: With no live condition, standby low and no remembered condition, `status_o` is 0 one cycle after the inputs settle.
- R2: If any bit of `short_flags_i` is 1 in a cycle, `status_o` is 1 in the following cycle.
- R3: If `overtemp_i` is 1 in a cycle, `status_o` is 1 in the following cycle, and the overtemperature event is remembered.
- R4: If `standby_i` is 1 in a cycle, `status_o` is 1 in the following cycle.
- R5: A pulse on `short_frame_i` (chip-select released after fewer than eight clocks) is remembered. It is released only by a `fall_pulse_i` with `fall_index_i` equal to 8.
- R6: A pulse on `long_frame_i` (the ninth rising clock of a frame) is remembered. It is released only by a `fall_pulse_i` with `fall_index_i` equal to 2.
- R7: A remembered overtemperature event is released by a `fall_pulse_i` with `fall_index_i` equal to 4, and only if `overtemp_i` is 0 in that same cycle.
- R8: When a set pulse and its release pulse arrive in the same cycle, the condition stays remembered.
- R9: A `fall_pulse_i` with any index other than 8, 2 or 4 releases nothing. A pulse with one of those indices releases only its own condition.
- R10: While `rst_n` is low, `status_o` is 1 and all remembered conditions are cleared. After reset is released with all inputs quiet, `status_o` falls to 0 after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| short_frame_i | input | 1 | One-cycle pulse: frame closed with too few clocks |
| long_frame_i | input | 1 | One-cycle pulse: ninth rising clock seen in a frame |
| fall_pulse_i | input | 1 | One-cycle pulse: a serial clock falling edge occurred |
| fall_index_i | input | 4 | 1-based index of that falling edge within the frame |
| short_flags_i | input | 8 | Live per-channel short-circuit flags |
| overtemp_i | input | 1 | Live overtemperature flag, already hysteresis-filtered |
| standby_i | input | 1 | High while all command bits are zero |
| status_o | output | 1 | Registered fault/self-test status line |

## Verification
The assertions assume three things about the inputs. The event pulses last one cycle. `fall_index_i` is meaningful only while `fall_pulse_i` is high. No input changes other than through the synchronous interface. The bench changes every input half a cycle away from the active edge and holds each pulse for exactly one cycle. It sweeps all 256 short-flag patterns and all 16 index values for each remembered condition, so every release edge and every non-release edge is exercised.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum int {
    SRC_SHORT = 0,
    SRC_LONG  = 1,
    SRC_OT    = 2
  } fsl_src_e;
  localparam int NUM_SRC = 3;
endpackage

// File: rtl/fsl_sticky.sv
module fsl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic q_next_o
);
  logic q;

  always_comb begin
    if (set_i)      q_next_o = 1'b1;
    else if (clr_i) q_next_o = 1'b0;
    else            q_next_o = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next_o;
  end

  assign q_o = q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> q_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!set_i && !clr_i) |=> $stable(q_o)); // R9
endmodule

// File: rtl/fsl_clear_decode.sv
module fsl_clear_decode #(
  parameter int IDX_W     = 4,
  parameter int SHORT_IDX = 8,
  parameter int LONG_IDX  = 2,
  parameter int OT_IDX    = 4
) (
  input  logic             fall_pulse_i,
  input  logic [IDX_W-1:0] fall_index_i,
  input  logic             ot_live_i,
  output logic [fsl_pkg::NUM_SRC-1:0] clr_o
);
  import fsl_pkg::*;

  localparam logic [IDX_W-1:0] K_SHORT = IDX_W'(SHORT_IDX);
  localparam logic [IDX_W-1:0] K_LONG  = IDX_W'(LONG_IDX);
  localparam logic [IDX_W-1:0] K_OT    = IDX_W'(OT_IDX);

  always_comb begin
    clr_o            = '0;
    clr_o[SRC_SHORT] = fall_pulse_i && (fall_index_i == K_SHORT);
    clr_o[SRC_LONG]  = fall_pulse_i && (fall_index_i == K_LONG);
    clr_o[SRC_OT]    = fall_pulse_i && (fall_index_i == K_OT) && !ot_live_i;
  end
endmodule

// File: rtl/fsl_live_or.sv
module fsl_live_or #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] short_flags_i,
  input  logic              overtemp_i,
  input  logic              standby_i,
  output logic              live_o
);
  assign live_o = (|short_flags_i) | overtemp_i | standby_i;
endmodule

// File: rtl/fault_status_latch.sv
module fault_status_latch #(
  parameter int NUM_CH    = 8,
  parameter int IDX_W     = 4,
  parameter int SHORT_IDX = 8,
  parameter int LONG_IDX  = 2,
  parameter int OT_IDX    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              short_frame_i,
  input  logic              long_frame_i,
  input  logic              fall_pulse_i,
  input  logic [IDX_W-1:0]  fall_index_i,
  input  logic [NUM_CH-1:0] short_flags_i,
  input  logic              overtemp_i,
  input  logic              standby_i,
  output logic              status_o
);
  import fsl_pkg::*;

  logic [NUM_SRC-1:0] set_v, clr_v, q_v, qn_v;
  logic live;
  logic status_q;

  always_comb begin
    set_v            = '0;
    set_v[SRC_SHORT] = short_frame_i;
    set_v[SRC_LONG]  = long_frame_i;
    set_v[SRC_OT]    = overtemp_i;
  end

  fsl_clear_decode #(
    .IDX_W(IDX_W), .SHORT_IDX(SHORT_IDX), .LONG_IDX(LONG_IDX), .OT_IDX(OT_IDX)
  ) u_dec (
    .fall_pulse_i(fall_pulse_i),
    .fall_index_i(fall_index_i),
    .ot_live_i(overtemp_i),
    .clr_o(clr_v)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fsl_sticky u_sticky (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_v[g]), .clr_i(clr_v[g]),
      .q_o(q_v[g]), .q_next_o(qn_v[g])
    );
  end

  fsl_live_or #(.NUM_CH(NUM_CH)) u_live (
    .short_flags_i(short_flags_i),
    .overtemp_i(overtemp_i),
    .standby_i(standby_i),
    .live_o(live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b1;
    else        status_q <= live | (|qn_v);
  end

  assign status_o = status_q;

  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (q_v == '0 && !short_frame_i && !long_frame_i && short_flags_i == '0 && !overtemp_i && !standby_i) |=> !status_o); // R1
  AST_LIVE_SHORT: assert property (@(posedge clk) disable iff (!rst_n) (|short_flags_i) |=> status_o); // R2
  AST_LIVE_OT: assert property (@(posedge clk) disable iff (!rst_n) overtemp_i |=> (status_o && q_v[SRC_OT])); // R3
  AST_STANDBY: assert property (@(posedge clk) disable iff (!rst_n) standby_i |=> status_o); // R4
  AST_SHORT_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pulse_i && fall_index_i == IDX_W'(SHORT_IDX) && !short_frame_i) |=> !q_v[SRC_SHORT]); // R5
  AST_LONG_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pulse_i && fall_index_i == IDX_W'(LONG_IDX) && !long_frame_i) |=> !q_v[SRC_LONG]); // R6
  AST_OT_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (q_v[SRC_OT] && overtemp_i) |=> q_v[SRC_OT]); // R7
  AST_REMEMBERED_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (|q_v) |-> status_o); // R9
endmodule

// File: tb/fault_status_latch_bench.sv
module fault_status_latch_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       short_frame_i = 1'b0, long_frame_i = 1'b0, fall_pulse_i = 1'b0;
  logic [3:0] fall_index_i = '0;
  logic [7:0] short_flags_i = '0;
  logic       overtemp_i = 1'b0, standby_i = 1'b0;
  logic       status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  fault_status_latch u_fault_status_latch (
    .clk(clk), .rst_n(rst_n),
    .short_frame_i(short_frame_i), .long_frame_i(long_frame_i),
    .fall_pulse_i(fall_pulse_i), .fall_index_i(fall_index_i),
    .short_flags_i(short_flags_i), .overtemp_i(overtemp_i),
    .standby_i(standby_i), .status_o(status_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    n_cmp++;
    if (status_o !== exp) begin
      n_bad++;
      $display("FAIL %s: status_o=%b expected %b", req, status_o, exp);
    end
  endtask

  task automatic pulse_fall(input int idx);
    fall_pulse_i = 1'b1;
    fall_index_i = 4'(idx);
    step();
    fall_pulse_i = 1'b0;
    fall_index_i = '0;
  endtask

  task automatic quiet();
    pulse_fall(8); pulse_fall(2);
    overtemp_i = 1'b0;
    pulse_fall(4);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R10", 1'b1);
    step();
    chk("R10", 1'b1);
    rst_n = 1'b1;
    step();
    chk("R10", 1'b0);
    chk("R1", 1'b0);

    // R2 / R1: every short-flag pattern
    for (int v = 0; v < 256; v++) begin
      short_flags_i = 8'(v);
      step();
      chk(v == 0 ? "R1" : "R2", v != 0);
    end
    short_flags_i = '0;
    step();
    chk("R1", 1'b0);

    // R4 standby
    standby_i = 1'b1; step(); chk("R4", 1'b1);
    standby_i = 1'b0; step(); chk("R4", 1'b0);

    // R5 / R9: short-frame latch, each single index
    for (int k = 0; k < 16; k++) begin
      short_frame_i = 1'b1; step(); short_frame_i = 1'b0;
      chk("R5", 1'b1);
      pulse_fall(k);
      chk(k == 8 ? "R5" : "R9", k != 8);
      quiet(); chk("R5", 1'b0);
    end
    // R5: full frame of clocks 1..8
    short_frame_i = 1'b1; step(); short_frame_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      pulse_fall(k);
      chk("R5", k != 8);
    end

    // R6 / R9: long-frame latch
    for (int k = 0; k < 16; k++) begin
      long_frame_i = 1'b1; step(); long_frame_i = 1'b0;
      chk("R6", 1'b1);
      pulse_fall(k);
      chk(k == 2 ? "R6" : "R9", k != 2);
      quiet(); chk("R6", 1'b0);
    end

    // R3 / R7 / R9: overtemperature latch, flag gone before clear
    for (int k = 0; k < 16; k++) begin
      overtemp_i = 1'b1; step(); chk("R3", 1'b1);
      overtemp_i = 1'b0; step(); chk("R3", 1'b1);
      pulse_fall(k);
      chk(k == 4 ? "R7" : "R9", k != 4);
      quiet(); chk("R7", 1'b0);
    end
    // R7: clear refused while overtemperature still present
    overtemp_i = 1'b1; step();
    pulse_fall(4); chk("R7", 1'b1);
    overtemp_i = 1'b0; step(); chk("R7", 1'b1);
    pulse_fall(4); chk("R7", 1'b0);

    // R8: set and release in the same cycle
    short_frame_i = 1'b1; fall_pulse_i = 1'b1; fall_index_i = 4'd8;
    step();
    short_frame_i = 1'b0; fall_pulse_i = 1'b0; fall_index_i = '0;
    chk("R8", 1'b1);
    step(); chk("R8", 1'b1);
    long_frame_i = 1'b1; fall_pulse_i = 1'b1; fall_index_i = 4'd2;
    step();
    long_frame_i = 1'b0; fall_pulse_i = 1'b0; fall_index_i = '0;
    pulse_fall(8); chk("R8", 1'b1);
    pulse_fall(2); chk("R8", 1'b0);

    // R9: a release edge only releases its own condition
    short_frame_i = 1'b1; long_frame_i = 1'b1; step();
    short_frame_i = 1'b0; long_frame_i = 1'b0;
    pulse_fall(2); chk("R9", 1'b1);
    pulse_fall(4); chk("R9", 1'b1);
    pulse_fall(8); chk("R9", 1'b0);

    // R10: reset in the middle of a remembered fault
    short_frame_i = 1'b1; step(); short_frame_i = 1'b0;
    rst_n = 1'b0; #1; chk("R10", 1'b1);
    step(); rst_n = 1'b1;
    step(); chk("R10", 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule